// File: doc/BRIEF.md
# Tiny Register CPU with Synchronous Data Memory

A single-cycle, non-pipelined processor with an 8-bit signed datapath. Seven architectural registers form one bank: index 0 is a constant zero, index 1 is the program counter, and indices 2 to 6 are the general registers A to E. Each cycle the instruction addressed by the program counter is fetched combinationally from a constant program image, decoded, passed through a five-function ALU, and the register bank is updated.

Data lives in a 32-word memory with a registered read and a clocked write. Because a read address only yields data after the next edge, a load's destination index is carried one cycle in a register and the memory output is written back on the following cycle. Software must leave one instruction between a load and the first use of its destination. The read data of the memory is the block's only output. The default program image computes the greatest common divisor of 4 and 6 and leaves 2 in memory word 2.

Top module: `tiny_cpu`

## Requirements
- R1: An active-low reset (asynchronous assert) clears every register, the program counter and the delayed load index to 0; after release execution restarts at address 0 while memory contents are kept.
- R2: An instruction is a 24-bit word: opcode in bits 23:21 (0 compute, 1 branch, 2 jump, 3 load, 4 store, 7 no-op; 5 and 6 act as no-op), ALU function in 20:18, source X in 17:15, source Y in 14:12, destination in 11:9, signed offset in 7:0 and memory address in 4:0. Register index 0 is zero, 1 is the PC, 2 to 6 are A to E; index 7 reads as 0 and writes to it are lost.
- R3: ALU function codes: 0 gives X+Y, 1 gives X-Y, 2 gives X+1, 3 passes X, 4 gives 1 if X>Y as signed values else 0; codes 5 to 7 pass X. Results wrap modulo 256.
- R4: Register 0 always reads 0; any write aimed at it is discarded.
- R5: The PC advances by 1 except on a branch whose source register is nonzero, which sets PC to PC plus the signed offset.
- R6: A jump always sets PC to PC plus the signed offset, forward or backward.
- R7: A store writes source register X to the addressed word; no other opcode writes memory.
- R8: The read address is the load's address field, and 0 for every other opcode; the addressed word appears on the output one clock after it is presented.
- R9: When a store writes the word being read in the same cycle, the output shows the word's previous value.
- R10: A load's value enters its destination register one cycle after the load; the instruction right after the load still sees the old value.
- R11: The program image is a parameter; addresses at or beyond its length execute as no-ops. The default GCD program shows 4, then 6 after the second load, then 4 until 2 appears 32 clocks after reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| mem_rdata | output | 8 | Registered read data of the data memory |

## Verification
Internal state only reaches the port through the memory, so a wrong register value stays hidden until a store writes it and a later load reads it back, normally two to four clocks after the fault. A wrong program counter shows sooner as a skipped or repeated load, moving the output's change by at least one clock, and a late or early write-back shows as a stored value that is stale or fresh one instruction off. The directed programs therefore store every computed value and load it back at a known clock, so each fault lands on a predicted output sample.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;

  localparam int DATA_W  = 8;
  localparam int INSTR_W = 24;
  localparam int RIDX_W  = 3;
  localparam int NREG    = 7;
  localparam int MEM_AW  = 5;
  localparam int GCD_LEN = 26;

  localparam logic [2:0] OPC_COMPUTE = 3'd0;
  localparam logic [2:0] OPC_BRANCH  = 3'd1;
  localparam logic [2:0] OPC_JUMP    = 3'd2;
  localparam logic [2:0] OPC_LOAD    = 3'd3;
  localparam logic [2:0] OPC_STORE   = 3'd4;
  localparam logic [2:0] OPC_NOP     = 3'd7;

  localparam logic [2:0] RG_ZERO = 3'd0;
  localparam logic [2:0] RG_PC   = 3'd1;
  localparam logic [2:0] RG_A    = 3'd2;
  localparam logic [2:0] RG_B    = 3'd3;
  localparam logic [2:0] RG_C    = 3'd4;
  localparam logic [2:0] RG_D    = 3'd5;
  localparam logic [2:0] RG_E    = 3'd6;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_INCR = 3'd2,
    ALU_PASS = 3'd3,
    ALU_GT   = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic [RIDX_W-1:0] src_x;
    logic [RIDX_W-1:0] src_y;
    logic [RIDX_W-1:0] dst;
    alu_op_e           op;
    logic [RIDX_W-1:0] ld_dst;
    logic [MEM_AW-1:0] rd_addr;
    logic              wr_en;
    logic [MEM_AW-1:0] wr_addr;
    logic              jump_en;
    logic [DATA_W-1:0] offset;
  } ctrl_t;

  function automatic logic [INSTR_W-1:0] enc(logic [2:0] opc, logic [2:0] fn,
      logic [2:0] x, logic [2:0] y, logic [2:0] d, logic [7:0] imm);
    return {opc, fn, x, y, d, 1'b0, imm};
  endfunction

  function automatic logic [INSTR_W-1:0] op_c(alu_op_e fn, logic [2:0] x,
      logic [2:0] y, logic [2:0] d);
    return enc(OPC_COMPUTE, fn, x, y, d, 8'd0);
  endfunction

  function automatic logic [INSTR_W-1:0] op_br(logic [2:0] x, logic [7:0] off);
    return enc(OPC_BRANCH, 3'd0, x, 3'd0, 3'd0, off);
  endfunction

  function automatic logic [INSTR_W-1:0] op_jmp(logic [7:0] off);
    return enc(OPC_JUMP, 3'd0, 3'd0, 3'd0, 3'd0, off);
  endfunction

  function automatic logic [INSTR_W-1:0] op_ld(logic [4:0] a, logic [2:0] d);
    return enc(OPC_LOAD, 3'd0, 3'd0, 3'd0, d, {3'b000, a});
  endfunction

  function automatic logic [INSTR_W-1:0] op_st(logic [2:0] x, logic [4:0] a);
    return enc(OPC_STORE, 3'd0, x, 3'd0, 3'd0, {3'b000, a});
  endfunction

  function automatic logic [INSTR_W-1:0] op_nop();
    return enc(OPC_NOP, 3'd0, 3'd0, 3'd0, 3'd0, 8'd0);
  endfunction

  // Default image: greatest common divisor of 4 and 6, result to word 2.
  function automatic logic [GCD_LEN*INSTR_W-1:0] gcd_image();
    logic [INSTR_W-1:0]         w [GCD_LEN];
    logic [GCD_LEN*INSTR_W-1:0] img;
    w[0] = op_c(ALU_INCR, RG_ZERO, RG_A, RG_A);
    for (int i = 1; i <= 3; i++) w[i] = op_c(ALU_INCR, RG_A, RG_ZERO, RG_A);
    w[4] = op_st(RG_A, 5'd0);
    w[5] = op_c(ALU_INCR, RG_ZERO, RG_A, RG_A);
    for (int i = 6; i <= 10; i++) w[i] = op_c(ALU_INCR, RG_A, RG_ZERO, RG_A);
    w[11] = op_st(RG_A, 5'd1);
    w[12] = op_ld(5'd0, RG_A);
    w[13] = op_ld(5'd1, RG_B);
    w[14] = op_nop();
    w[15] = op_c(ALU_GT, RG_A, RG_B, RG_C);
    w[16] = op_br(RG_C, 8'sd4);
    w[17] = op_c(ALU_GT, RG_B, RG_A, RG_C);
    w[18] = op_br(RG_C, 8'sd4);
    w[19] = op_jmp(8'sd5);
    w[20] = op_c(ALU_SUB, RG_A, RG_B, RG_A);
    w[21] = op_jmp(-8'sd6);
    w[22] = op_c(ALU_SUB, RG_B, RG_A, RG_B);
    w[23] = op_jmp(-8'sd8);
    w[24] = op_st(RG_A, 5'd2);
    w[25] = op_ld(5'd2, RG_C);
    img = '0;
    for (int i = 0; i < GCD_LEN; i++) img[i*INSTR_W +: INSTR_W] = w[i];
    return img;
  endfunction

endpackage

// File: rtl/tcpu_decode.sv
module tcpu_decode
  import tcpu_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ctrl_t              ctrl
);

  logic unused_rsvd;
  assign unused_rsvd = instr[8];

  always_comb begin
    ctrl         = '0;
    ctrl.op      = ALU_PASS;
    case (instr[23:21])
      OPC_COMPUTE: begin
        ctrl.src_x = instr[17:15];
        ctrl.src_y = instr[14:12];
        ctrl.dst   = instr[11:9];
        ctrl.op    = alu_op_e'(instr[20:18]);
      end
      OPC_BRANCH: begin
        ctrl.src_x   = instr[17:15];
        ctrl.jump_en = 1'b1;
        ctrl.offset  = instr[7:0];
      end
      OPC_JUMP: begin
        ctrl.op      = ALU_INCR;
        ctrl.jump_en = 1'b1;
        ctrl.offset  = instr[7:0];
      end
      OPC_LOAD: begin
        ctrl.ld_dst  = instr[11:9];
        ctrl.rd_addr = instr[4:0];
      end
      OPC_STORE: begin
        ctrl.src_x   = instr[17:15];
        ctrl.wr_en   = 1'b1;
        ctrl.wr_addr = instr[4:0];
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tcpu_alu.sv
module tcpu_alu
  import tcpu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  alu_op_e              op,
  input  logic signed [W-1:0]  a,
  input  logic signed [W-1:0]  b,
  output logic signed [W-1:0]  y
);

  always_comb begin
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_INCR: y = a + W'(1);
      ALU_GT:   y = (a > b) ? W'(1) : '0;
      default:  y = a;
    endcase
  end

endmodule

// File: rtl/tcpu_regbank.sv
module tcpu_regbank
  import tcpu_pkg::*;
#(
  parameter int W      = DATA_W,
  parameter int N      = NREG,
  parameter int IW     = RIDX_W,
  parameter int PC_IDX = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IW-1:0]        src_x,
  input  logic [IW-1:0]        src_y,
  input  logic [IW-1:0]        res_dst,
  input  logic [W-1:0]         res_data,
  input  logic [IW-1:0]        ld_dst,
  input  logic [W-1:0]         ld_data,
  input  logic [W-1:0]         next_pc,
  output logic signed [W-1:0]  x_val,
  output logic signed [W-1:0]  y_val,
  output logic [W-1:0]         pc
);

  logic [W-1:0]  regs_q [N];
  logic [W-1:0]  regs_d [N];
  logic [IW-1:0] ld_dst_q;
  logic [IW-1:0] ld_dst_d;

  // Read ports: indices with no entry read as zero.
  always_comb begin
    x_val = '0;
    y_val = '0;
    for (int i = 0; i < N; i++) begin
      if (src_x == IW'(i)) x_val = regs_q[i];
      if (src_y == IW'(i)) y_val = regs_q[i];
    end
  end

  assign pc = regs_q[PC_IDX];

  // Write priority, lowest first: delayed load, ALU result, PC, zero.
  always_comb begin
    regs_d   = regs_q;
    ld_dst_d = ld_dst;
    for (int i = 0; i < N; i++) begin
      if (ld_dst_q == IW'(i)) regs_d[i] = ld_data;
    end
    for (int i = 0; i < N; i++) begin
      if (res_dst == IW'(i)) regs_d[i] = res_data;
    end
    regs_d[PC_IDX] = next_pc;
    regs_d[0]      = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs_q[i] <= '0;
      ld_dst_q <= '0;
    end else begin
      regs_q   <= regs_d;
      ld_dst_q <= ld_dst_d;
    end
  end

endmodule

// File: rtl/tcpu_dmem.sv
module tcpu_dmem
  import tcpu_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int AW    = MEM_AW,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] mem [DEPTH];

  // Read returns the word as it stood before this edge's write.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/tiny_cpu.sv
module tiny_cpu
  import tcpu_pkg::*;
#(
  parameter int                        PROG_LEN   = GCD_LEN,
  parameter logic [PROG_LEN*INSTR_W-1:0] PROG_IMAGE = gcd_image()
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [DATA_W-1:0] mem_rdata
);

  localparam int IADDR_W = DATA_W;

  logic [IADDR_W-1:0]       pc;
  logic [INSTR_W-1:0]       instr;
  ctrl_t                    ctrl;
  logic signed [DATA_W-1:0] x_val;
  logic signed [DATA_W-1:0] y_val;
  logic signed [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0]        next_pc;
  logic                     dmem_we;

  // Program image lookup; addresses past the image fetch a no-op.
  always_comb begin
    instr = op_nop();
    for (int i = 0; i < PROG_LEN; i++) begin
      if (pc == IADDR_W'(i)) instr = PROG_IMAGE[i*INSTR_W +: INSTR_W];
    end
  end

  tcpu_decode u_dec (
    .instr (instr),
    .ctrl  (ctrl)
  );

  tcpu_alu #(.W(DATA_W)) u_alu (
    .op (ctrl.op),
    .a  (x_val),
    .b  (y_val),
    .y  (alu_y)
  );

  always_comb begin
    if (ctrl.jump_en && (alu_y != '0)) next_pc = pc + ctrl.offset;
    else                               next_pc = pc + DATA_W'(1);
  end

  tcpu_regbank #(.W(DATA_W), .N(NREG), .IW(RIDX_W), .PC_IDX(int'(RG_PC))) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_x    (ctrl.src_x),
    .src_y    (ctrl.src_y),
    .res_dst  (ctrl.dst),
    .res_data (alu_y),
    .ld_dst   (ctrl.ld_dst),
    .ld_data  (mem_rdata),
    .next_pc  (next_pc),
    .x_val    (x_val),
    .y_val    (y_val),
    .pc       (pc)
  );

  assign dmem_we = ctrl.wr_en;

  tcpu_dmem #(.W(DATA_W), .AW(MEM_AW)) u_mem (
    .clk     (clk),
    .rd_addr (ctrl.rd_addr),
    .wr_en   (dmem_we),
    .wr_addr (ctrl.wr_addr),
    .wr_data (alu_y),
    .rd_data (mem_rdata)
  );

endmodule

// File: rtl/tcpu_checker.sv
module tcpu_checker
  import tcpu_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic [DATA_W-1:0]        pc,
  input logic [2:0]               opc,
  input logic [RIDX_W-1:0]        xsel,
  input logic [7:0]               offs,
  input logic signed [DATA_W-1:0] x_val,
  input logic                     dmem_we
);

  assert_store_only_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (opc == OPC_STORE));

  assert_pc_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opc != OPC_BRANCH && opc != OPC_JUMP) |=> (pc == $past(pc) + 8'd1));

  assert_branch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_BRANCH && x_val == 0) |=> (pc == $past(pc) + 8'd1));

  assert_branch_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_BRANCH && x_val != 0) |=> (pc == $past(pc) + $past(offs)));

  assert_jump_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_JUMP) |=> (pc == $past(pc) + $past(offs)));

  assert_zero_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xsel == RG_ZERO) |-> (x_val == 0));

endmodule

bind tiny_cpu tcpu_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pc      (pc),
  .opc     (instr[23:21]),
  .xsel    (instr[17:15]),
  .offs    (instr[7:0]),
  .x_val   (x_val),
  .dmem_we (dmem_we)
);

// File: tb/tiny_cpu_test.sv
module tiny_cpu_test;
  import tcpu_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int ALU_LEN    = 43;

  function automatic logic [ALU_LEN*INSTR_W-1:0] alu_image();
    logic [INSTR_W-1:0]         w [ALU_LEN];
    logic [ALU_LEN*INSTR_W-1:0] img;
    w[0]  = op_c(ALU_INCR, RG_ZERO, RG_A, RG_A);
    w[1]  = op_c(ALU_INCR, RG_A, RG_ZERO, RG_A);
    w[2]  = op_c(ALU_INCR, RG_A, RG_ZERO, RG_A);
    w[3]  = op_c(ALU_ADD, RG_A, RG_A, RG_B);
    w[4]  = op_c(ALU_SUB, RG_A, RG_B, RG_C);
    w[5]  = op_c(ALU_GT, RG_A, RG_C, RG_D);
    w[6]  = op_c(ALU_GT, RG_C, RG_A, RG_E);
    w[7]  = op_st(RG_B, 5'd3);
    w[8]  = op_st(RG_C, 5'd4);
    w[9]  = op_st(RG_D, 5'd5);
    w[10] = op_st(RG_E, 5'd6);
    w[11] = op_ld(5'd3, RG_ZERO);
    w[12] = op_ld(5'd4, RG_ZERO);
    w[13] = op_ld(5'd5, RG_ZERO);
    w[14] = op_ld(5'd6, RG_ZERO);
    w[15] = op_ld(5'd4, RG_E);
    w[16] = op_st(RG_E, 5'd7);
    w[17] = op_st(RG_E, 5'd8);
    w[18] = op_ld(5'd7, RG_ZERO);
    w[19] = op_ld(5'd8, RG_ZERO);
    w[20] = op_c(ALU_INCR, RG_A, RG_ZERO, RG_ZERO);
    w[21] = op_st(RG_ZERO, 5'd3);
    w[22] = op_ld(5'd3, RG_ZERO);
    w[23] = op_st(RG_B, 5'd0);
    w[24] = op_st(RG_A, 5'd0);
    w[25] = op_nop();
    w[26] = op_st(RG_ZERO, 5'd10);
    w[27] = op_br(RG_E, 8'sd2);
    w[28] = op_st(RG_A, 5'd10);
    w[29] = op_br(RG_ZERO, 8'sd5);
    w[30] = op_st(RG_D, 5'd11);
    w[31] = op_ld(5'd10, RG_ZERO);
    w[32] = op_ld(5'd11, RG_ZERO);
    w[33] = op_jmp(8'sd3);
    w[34] = op_st(RG_A, 5'd11);
    w[35] = op_nop();
    w[36] = op_ld(5'd11, RG_ZERO);
    w[37] = op_c(ALU_INCR, 3'd7, RG_ZERO, RG_A);
    w[38] = op_st(RG_A, 5'd12);
    w[39] = op_ld(5'd12, RG_ZERO);
    w[40] = op_c(ALU_PASS, RG_C, RG_ZERO, RG_D);
    w[41] = op_st(RG_D, 5'd13);
    w[42] = op_ld(5'd13, RG_ZERO);
    img = '0;
    for (int i = 0; i < ALU_LEN; i++) img[i*INSTR_W +: INSTR_W] = w[i];
    return img;
  endfunction

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_alu_n = 1'b0;
  logic [7:0] gcd_out;
  logic [7:0] alu_out;
  int         n_tests = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiny_cpu uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdata (gcd_out)
  );

  tiny_cpu #(.PROG_LEN(ALU_LEN), .PROG_IMAGE(alu_image())) uut_alu (
    .clk       (clk),
    .rst_n     (rst_alu_n),
    .mem_rdata (alu_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // First pass of the GCD image; words 0..5 unchecked (memory not yet written).
  task automatic gcd_first_pass();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int s = 1; s <= 33; s++) begin
      step();
      if (s == 6)       check("R7 store of 4 visible", gcd_out, 8'd4);
      else if (s == 14) check("R8 second load shows 6", gcd_out, 8'd6);
      else if (s == 32) check("R11 gcd result 2", gcd_out, 8'd2);
      else if (s > 6)   check("R11 gcd trace", gcd_out, 8'd4);
    end
  endtask

  // Mid-run reset: program restarts at 0, memory keeps its words.
  task automatic gcd_reset_rerun();
    #2 rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    for (int s = 1; s <= 33; s++) begin
      step();
      if (s == 14)      check("R1 restart trace load 6", gcd_out, 8'd6);
      else if (s == 32) check("R1 restart trace result", gcd_out, 8'd2);
      else              check("R1 restart trace", gcd_out, 8'd4);
    end
  endtask

  task automatic alu_program();
    rst_alu_n = 1'b1;
    for (int s = 1; s <= 45; s++) begin
      step();
      case (s)
        12: check("R3 add", alu_out, 8'h06);
        13: check("R3 sub negative", alu_out, 8'hFD);
        14: check("R3 signed greater true", alu_out, 8'h01);
        15: check("R3 signed greater false", alu_out, 8'h00);
        19: check("R10 stale value after load", alu_out, 8'h00);
        20: check("R10 loaded value one cycle later", alu_out, 8'hFD);
        23: check("R4 write to zero discarded", alu_out, 8'h00);
        25: check("R9 read during write old data", alu_out, 8'h06);
        26: check("R7 overwrite visible", alu_out, 8'h03);
        31: check("R5 taken branch skipped store", alu_out, 8'h00);
        32: check("R5 untaken branch falls through", alu_out, 8'h01);
        34: check("R6 jump skipped store", alu_out, 8'h01);
        37: check("R2 index 7 reads zero", alu_out, 8'h01);
        40: check("R3 pass through", alu_out, 8'hFD);
        default: if (s >= 41) check("R11 past image is no-op", alu_out, 8'h03);
      endcase
    end
  endtask

  initial begin
    gcd_first_pass();
    gcd_reset_rerun();
    alu_program();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule